// File: doc/BRIEF.md
# Card Command Line Transmitter

This block sends one 48-bit command frame to a memory card over a single serial command line. Software loads five bytes through a byte write port: a command index byte first, then a 32-bit argument, most significant byte first. The bytes go into a small transmit FIFO. Software sets a command-enable control bit and then clears it. When the bit is cleared, the block locks the FIFO and shifts the frame out, one bit for each tick of a clock-enable input.

The frame is a start bit of 0 and a transmission bit of 1, followed by the low six bits of the index byte and the 32 argument bits. A CRC7 is computed serially over those first 40 bits and appended after them, and an end bit of 1 closes the frame. When the frame is complete, the lock is released and a sticky end-of-command flag is raised for use as an interrupt request. A separate pointer-reset control bit, set and then cleared, abandons a partially loaded command.

Top module: `cmd_line_tx`

## Requirements
- R1: After reset, cmd_out is 1, lock is 0 and eoc is 0.
- R2: Bytes written with wr_en fill FIFO slots 0 to 4 in order. Slot 0 is the index byte and slots 1 to 4 are the argument, most significant byte first. Writes after the fifth byte are ignored.
- R3: A transmission starts on the clock edge where cmd_en is seen low after having been high the cycle before. Holding cmd_en high starts nothing.
- R4: lock is 1 from the cycle after the start edge until the frame ends. wr_en writes are ignored while lock is 1, and an accepted start returns the write pointer to slot 0.
- R5: The frame is, in transmit order: bit 0, bit 1, bits 5..0 of the index byte (bits 7..6 of the byte are replaced), the 32 argument bits MSB first, the 7 CRC bits MSB first, and an end bit 1. That is 48 bits.
- R6: The CRC uses polynomial x^7+x^3+1 with a zero seed over the first 40 frame bits. For example, index 0x00 with argument 0 gives CRC 0x4A, and index 0x08 with argument 0x000001AA gives 0x43.
- R7: The line idles at 1. It changes only on a clock edge where bit_tick is 1, and each such tick while locked advances one frame bit.
- R8: The 48th tick puts the end bit on the line. The 49th tick clears lock and sets eoc in the same cycle.
- R9: eoc stays 1 until a cycle with eoc_clr is 1. If the end of a frame and eoc_clr fall in the same cycle, eoc ends at 1.
- R10: A falling edge of ptr_rst (high one cycle, low the next) returns the write pointer to slot 0, so the next write lands in the index slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe into the FIFO |
| wr_data | input | 8 | Byte to write |
| cmd_en | input | 1 | Command-enable control bit; falling edge starts sending |
| ptr_rst | input | 1 | Pointer-reset control bit; falling edge clears the write pointer |
| bit_tick | input | 1 | Clock enable, one frame bit per tick |
| eoc_clr | input | 1 | Write-one-to-clear pulse for eoc |
| cmd_out | output | 1 | Serial command line |
| lock | output | 1 | FIFO write lock, high while a frame is in flight |
| eoc | output | 1 | Sticky end-of-command flag |

## Verification
The checker treats cmd_en and ptr_rst as level control bits whose falling edge is the event. It also expects bit_tick to be a plain enable that may stay low for any number of cycles. The stimulus drives every control input on the falling clock edge and raises bit_tick for one cycle in three. This gives the line-stability property idle cycles to check between ticks. The stimulus also writes while locked, fires eoc_clr in the same cycle as the final tick, and holds cmd_en high without clearing it. Each of these exercises an assumption at its edge and stays legal.

// File: rtl/cltx_pkg.sv
package cltx_pkg;
   typedef logic [7:0] byte_t;

   function automatic logic [6:0] crc7_step(input logic [6:0] cur, input logic din,
                                             input logic [6:0] poly);
      logic fb;
      fb = din ^ cur[6];
      return {cur[5:0], 1'b0} ^ (fb ? poly : 7'd0);
   endfunction
endpackage

// File: rtl/cltx_fall.sv
module cltx_fall (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic lvl_q,
   output logic fall
);
   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end
   assign fall = lvl_q & ~lvl;
endmodule

// File: rtl/cltx_fifo.sv
module cltx_fifo #(
   parameter int NBYTES = 5,
   parameter int PTR_W  = $clog2(NBYTES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [7:0]            wr_data,
   input  logic                  ptr_clr,
   input  logic                  lock,
   output logic [NBYTES*8-1:0]   flat,
   output logic [PTR_W-1:0]      wr_ptr
);
   logic accept;
   assign accept = wr_en && !lock && !ptr_clr && (wr_ptr < PTR_W'(NBYTES));

   always_ff @(posedge clk) begin
      if (!rst_n)       wr_ptr <= '0;
      else if (ptr_clr) wr_ptr <= '0;
      else if (accept)  wr_ptr <= wr_ptr + 1'b1;
   end

   for (genvar g = 0; g < NBYTES; g++) begin : g_slot
      cltx_pkg::byte_t slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                                   slot_q <= '0;
         else if (accept && wr_ptr == PTR_W'(g))       slot_q <= wr_data;
      end
      assign flat[(NBYTES-1-g)*8 +: 8] = slot_q;
   end
endmodule

// File: rtl/cltx_crc7.sv
module cltx_crc7 #(
   parameter logic [6:0] POLY = 7'h09
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic upd,
   input  logic shift,
   input  logic din,
   output logic msb
);
   logic [6:0] crc_q;
   always_ff @(posedge clk) begin
      if (!rst_n)     crc_q <= '0;
      else if (clr)   crc_q <= '0;
      else if (upd)   crc_q <= cltx_pkg::crc7_step(crc_q, din, POLY);
      else if (shift) crc_q <= {crc_q[5:0], 1'b0};
   end
   assign msb = crc_q[6];
endmodule

// File: rtl/cltx_serializer.sv
module cltx_serializer #(
   parameter int DATA_W  = 40,
   parameter int CRC_W   = 7,
   parameter int FRAME_W = DATA_W + CRC_W + 1,
   parameter int CNT_W   = $clog2(FRAME_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_edge,
   input  logic              bit_tick,
   input  logic              eoc_clr,
   input  logic [DATA_W-1:0] frame_i,
   input  logic              crc_msb,
   output logic              start_go,
   output logic              crc_upd,
   output logic              crc_shift,
   output logic              data_bit,
   output logic              line_q,
   output logic              lock_q,
   output logic              eoc_q
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] sel;
   logic             step, done, nxt_bit;

   assign start_go  = start_edge && !lock_q;
   assign step      = lock_q && bit_tick;
   assign done      = step && (cnt_q == CNT_W'(FRAME_W));
   assign sel       = CNT_W'(DATA_W - 1) - cnt_q;
   assign data_bit  = frame_i[sel];
   assign crc_upd   = step && (cnt_q < CNT_W'(DATA_W));
   assign crc_shift = step && (cnt_q >= CNT_W'(DATA_W)) && (cnt_q < CNT_W'(DATA_W + CRC_W));

   always_comb begin
      if (cnt_q < CNT_W'(DATA_W))              nxt_bit = data_bit;
      else if (cnt_q < CNT_W'(DATA_W + CRC_W)) nxt_bit = crc_msb;
      else                                     nxt_bit = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         cnt_q  <= '0;
         line_q <= 1'b1;
      end else if (start_go) begin
         lock_q <= 1'b1;
         cnt_q  <= '0;
      end else if (done) begin
         lock_q <= 1'b0;
         line_q <= 1'b1;
      end else if (step) begin
         line_q <= nxt_bit;
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       eoc_q <= 1'b0;
      else if (done)    eoc_q <= 1'b1;
      else if (eoc_clr) eoc_q <= 1'b0;
   end
endmodule

// File: rtl/cmd_line_tx.sv
module cmd_line_tx #(
   parameter int         IDX_W    = 6,
   parameter int         ARG_W    = 32,
   parameter logic [6:0] CRC_POLY = 7'h09
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       cmd_en,
   input  logic       ptr_rst,
   input  logic       bit_tick,
   input  logic       eoc_clr,
   output logic       cmd_out,
   output logic       lock,
   output logic       eoc
);
   localparam int CRC_W   = 7;
   localparam int DATA_W  = 2 + IDX_W + ARG_W;
   localparam int NBYTES  = DATA_W / 8;
   localparam int FRAME_W = DATA_W + CRC_W + 1;
   localparam int PTR_W   = $clog2(NBYTES + 1);

   initial begin
      if (DATA_W % 8 != 0) $error("index plus argument plus two lead bits must fill whole bytes");
      if (IDX_W < 1)       $error("index width must be positive");
   end

   logic              en_q, en_fall, pr_q, pr_fall, start_go;
   logic              crc_upd, crc_shift, crc_msb, data_bit;
   logic [DATA_W-1:0] flat, frame;
   logic [PTR_W-1:0]  wr_ptr;

   cltx_fall u_en_edge (.clk(clk), .rst_n(rst_n), .lvl(cmd_en),  .lvl_q(en_q), .fall(en_fall));
   cltx_fall u_pr_edge (.clk(clk), .rst_n(rst_n), .lvl(ptr_rst), .lvl_q(pr_q), .fall(pr_fall));

   cltx_fifo #(.NBYTES(NBYTES), .PTR_W(PTR_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .ptr_clr(pr_fall || start_go), .lock(lock), .flat(flat), .wr_ptr(wr_ptr));

   assign frame = {2'b01, flat[DATA_W-3:0]};

   cltx_crc7 #(.POLY(CRC_POLY)) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(start_go), .upd(crc_upd), .shift(crc_shift),
      .din(data_bit), .msb(crc_msb));

   cltx_serializer #(.DATA_W(DATA_W), .CRC_W(CRC_W), .FRAME_W(FRAME_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .start_edge(en_fall), .bit_tick(bit_tick),
      .eoc_clr(eoc_clr), .frame_i(frame), .crc_msb(crc_msb), .start_go(start_go),
      .crc_upd(crc_upd), .crc_shift(crc_shift), .data_bit(data_bit),
      .line_q(cmd_out), .lock_q(lock), .eoc_q(eoc));
endmodule

// File: rtl/cltx_chk.sv
module cltx_chk #(
   parameter int NBYTES = 5,
   parameter int PTR_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_en,
   input logic             en_q,
   input logic             bit_tick,
   input logic             eoc_clr,
   input logic             cmd_out,
   input logic             lock,
   input logic             eoc,
   input logic [PTR_W-1:0] wr_ptr
);
   // R2
   ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ptr <= PTR_W'(NBYTES));
   // R3
   start_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q && !cmd_en && !lock |=> lock);
   // R4
   locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> (wr_ptr <= $past(wr_ptr)));
   // R7
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lock |-> cmd_out);
   // R7
   tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(cmd_out));
   // R8
   end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock) |-> eoc);
   // R9
   eoc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoc && !eoc_clr |=> eoc);
endmodule

bind cmd_line_tx cltx_chk #(.NBYTES(NBYTES), .PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .en_q(en_q), .bit_tick(bit_tick),
   .eoc_clr(eoc_clr), .cmd_out(cmd_out), .lock(lock), .eoc(eoc), .wr_ptr(wr_ptr));

// File: tb/cmd_line_tx_tb.sv
module cmd_line_tx_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       cmd_en = 1'b0;
   logic       ptr_rst = 1'b0;
   logic       bit_tick = 1'b0;
   logic       eoc_clr = 1'b0;
   logic       cmd_out, lock, eoc;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         finished = 1'b0;

   localparam logic [47:0] F_CMD0  = 48'h40_0000_0000_95;
   localparam logic [47:0] F_CMD8  = 48'h48_0000_01AA_87;
   localparam logic [47:0] F_CMD17 = 48'h51_0000_0000_55;

   always #4 clk = ~clk;

   cmd_line_tx u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cmd_en(cmd_en),
      .ptr_rst(ptr_rst), .bit_tick(bit_tick), .eoc_clr(eoc_clr),
      .cmd_out(cmd_out), .lock(lock), .eoc(eoc));

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_byte(input logic [7:0] b);
      wr_en = 1'b1; wr_data = b;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load(input logic [7:0] idx, input logic [31:0] arg);
      wr_byte(idx);
      for (int i = 3; i >= 0; i--) wr_byte(arg[i*8 +: 8]);
   endtask

   task automatic pulse_en();
      cmd_en = 1'b1;
      @(negedge clk);
      cmd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic tick(input logic clr);
      bit_tick = 1'b1; eoc_clr = clr;
      @(negedge clk);
      bit_tick = 1'b0; eoc_clr = 1'b0;
      cyc(2);
   endtask

   task automatic send(output logic [47:0] got, input logic clr_last);
      for (int i = 0; i < 48; i++) begin
         tick(1'b0);
         got[47-i] = cmd_out;
      end
      tick(clr_last);
   endtask

   task automatic clear_eoc();
      eoc_clr = 1'b1;
      @(negedge clk);
      eoc_clr = 1'b0;
   endtask

   task automatic t_reset();
      check(cmd_out == 1'b1, "R1 line", cmd_out, 1);
      check(lock == 1'b0, "R1 lock", lock, 0);
      check(eoc == 1'b0, "R1 eoc", eoc, 0);
   endtask

   task automatic t_cmd0();
      logic [47:0] got;
      load(8'hC0, 32'h0);              // R5: top index bits replaced
      pulse_en();
      check(lock == 1'b1, "R4 lock set", lock, 1);
      check(cmd_out == 1'b1, "R7 idle before tick", cmd_out, 1);
      send(got, 1'b0);
      check(got == F_CMD0, "R5 R6 frame cmd0", got, F_CMD0);
      check(lock == 1'b0, "R8 lock clear", lock, 0);
      check(eoc == 1'b1, "R8 eoc set", eoc, 1);
      cyc(5);
      check(eoc == 1'b1, "R9 eoc sticky", eoc, 1);
      clear_eoc();
      check(eoc == 1'b0, "R9 eoc cleared", eoc, 0);
   endtask

   task automatic t_cmd8();
      logic [47:0] got;
      load(8'h08, 32'h0000_01AA);
      pulse_en();
      send(got, 1'b0);
      check(got == F_CMD8, "R6 frame cmd8", got, F_CMD8);
      clear_eoc();
   endtask

   task automatic t_locked_writes();
      logic [47:0] got;
      load(8'h11, 32'h0);
      pulse_en();
      for (int i = 0; i < 3; i++) wr_byte(8'hFF);   // R4: ignored
      send(got, 1'b0);
      check(got == F_CMD17, "R4 frame with locked writes", got, F_CMD17);
      clear_eoc();
      load(8'h08, 32'h0000_01AA);
      pulse_en();
      send(got, 1'b0);
      check(got == F_CMD8, "R4 pointer back at slot 0", got, F_CMD8);
      clear_eoc();
   endtask

   task automatic t_ptr_reset();
      logic [47:0] got;
      wr_byte(8'hAA); wr_byte(8'hBB);
      ptr_rst = 1'b1;
      @(negedge clk);
      ptr_rst = 1'b0;
      @(negedge clk);                  // R10
      load(8'h51, 32'h0);
      wr_byte(8'hFF);                  // R2: sixth byte ignored
      pulse_en();
      send(got, 1'b0);
      check(got == F_CMD17, "R10 R2 frame after pointer reset", got, F_CMD17);
      clear_eoc();
   endtask

   task automatic t_level_start();
      logic [47:0] got;
      cmd_en = 1'b1;
      cyc(10);
      check(lock == 1'b0, "R3 level does not start", lock, 0);
      cmd_en = 1'b0;
      @(negedge clk);
      check(lock == 1'b1, "R3 start on release", lock, 1);
      send(got, 1'b1);                 // R9: clear in the final tick
      check(got == F_CMD17, "R3 frame from kept contents", got, F_CMD17);
      check(eoc == 1'b1, "R9 set wins over clear", eoc, 1);
      clear_eoc();
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cmd0();
      t_cmd8();
      t_locked_writes();
      t_ptr_reset();
      t_level_start();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule